// File: doc/BRIEF.md
# Byte-Wide Frame Check Sequence Engine

This block computes the 16-bit frame check sequence used on slow-rate infrared serial links. Software feeds it one byte at a time through a 16-bit register bus. Each byte goes into the running checksum in a single clock cycle, so writes may come on consecutive cycles. The engine also keeps a 12-bit count of the bytes it has taken in since it was last cleared.

The checksum is the CCITT polynomial 0x1021 processed least-significant bit first, which is the reflected constant 0x8408. The running register starts at 0xFFFF, and the result register returns its ones' complement. Under this rule, clearing the engine and feeding the bytes 0xCC, 0xF5, 0xF1, 0xA7 gives the fixed self-test answer 0x51DF. Software can run that check at start-up to confirm the datapath before it protects any frames.

The bus has no wait states. A write takes effect at the clock edge where `bus_wr_en` is high. A read is combinational from `bus_addr` and shows the state after the most recent edge. No data stream leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `crc_byte_engine`

## Requirements
- R1: After the synchronous reset `rst`, the byte count reads 0, the raw register (address 3) reads 0xFFFF and the result register (address 2) reads 0x0000.
- R2: A write to the control register (address 0) with bit 15 set returns the running checksum to 0xFFFF and the count to 0, visible on the next cycle.
- R3: A control write with bit 15 clear changes neither the checksum nor the count.
- R4: A read of the control register returns the byte count in bits 11:0, with bits 15:12 reading 0, so the clear bit always reads back as 0.
- R5: A write to the feed register (address 1) takes in only bits 7:0 as one byte. Bits 15:8, bit 15 included, have no effect, and the count rises by one.
- R6: Writes to the feed register on consecutive cycles are each taken in, one byte per cycle.
- R7: The checksum is polynomial 0x1021, bit 0 of each byte first, starting value 0xFFFF, with the result the ones' complement. After a clear and the bytes 0xCC, 0xF5, 0xF1, 0xA7, the count reads 4 and the result reads 0x51DF.
- R8: The count saturates at 0xFFF. Bytes that arrive after that still update the checksum.
- R9: The result register (address 2) is always the complement of the raw register (address 3). Addresses 4 to 7 read 0. Writes to addresses 2 to 7 change nothing.
- R10: In a cycle with `bus_wr_en` low, the checksum and the count hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, a 3-bit address, a 16-bit checksum and a 12-bit count. A 12-bit count saturates after 4095 bytes, so a single back-to-back burst of a little over four thousand writes reaches the saturation corner within the run. The fixed self-test vector anchors the starting value and the output complement. Random byte streams are compared against a bit-at-a-time model. This exercises the eight-bit parallel update over many data patterns, including writes that set the upper data bits.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int unsigned BUS_W_DEF  = 16;
  localparam int unsigned ADDR_W_DEF = 3;
  localparam int unsigned CRC_W_DEF  = 16;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 12;

  // Reflected form of the CCITT polynomial 0x1021 (LSB-first processing)
  localparam logic [15:0] POLY_REFL_DEF = 16'h8408;
  localparam logic [15:0] SEED_DEF      = 16'hFFFF;

  // Bit of the control register that clears the engine
  localparam int unsigned CLR_BIT_DEF = 15;

  // Register map, word addresses
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_FEED  = 3'd1,
    REG_FCS   = 3'd2,
    REG_RAW   = 3'd3
  } reg_addr_e;

endpackage

// File: rtl/crc_byte_update.sv
// Combinational eight-step update of a reflected CRC: one byte per call.
module crc_byte_update #(
  parameter int unsigned         CRC_W  = 16,
  parameter int unsigned         BYTE_W = 8,
  parameter logic [CRC_W-1:0]    POLY_R = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);

  localparam int unsigned STEPS = BYTE_W;

  logic [CRC_W-1:0] stage [STEPS+1];

  assign stage[0] = crc_in ^ CRC_W'(byte_in);

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    logic [CRC_W-1:0] shifted;
    assign shifted      = stage[s] >> 1;
    assign stage[s+1]   = stage[s][0] ? (shifted ^ POLY_R) : shifted;
  end

  assign crc_out = stage[STEPS];

endmodule

// File: rtl/crc_sat_counter.sv
// Saturating up-counter with synchronous clear.
module crc_sat_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/crc_readback.sv
// Read multiplexer for the engine's registers.
module crc_readback #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CRC_W-1:0]  crc,
  output logic [BUS_W-1:0]  rdata
);

  import crc_eng_pkg::*;

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(REG_CTRL): rdata[CNT_W-1:0] = cnt;
      ADDR_W'(REG_FCS):  rdata[CRC_W-1:0] = ~crc;
      ADDR_W'(REG_RAW):  rdata[CRC_W-1:0] = crc;
      default:           rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_byte_engine.sv
// Register-mapped byte-wide frame check sequence engine.
module crc_byte_engine #(
  parameter int unsigned          BUS_W   = crc_eng_pkg::BUS_W_DEF,
  parameter int unsigned          ADDR_W  = crc_eng_pkg::ADDR_W_DEF,
  parameter int unsigned          CRC_W   = crc_eng_pkg::CRC_W_DEF,
  parameter int unsigned          BYTE_W  = crc_eng_pkg::BYTE_W_DEF,
  parameter int unsigned          CNT_W   = crc_eng_pkg::CNT_W_DEF,
  parameter logic [CRC_W-1:0]     POLY_R  = crc_eng_pkg::POLY_REFL_DEF,
  parameter logic [CRC_W-1:0]     SEED    = crc_eng_pkg::SEED_DEF,
  parameter int unsigned          CLR_BIT = crc_eng_pkg::CLR_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);

  import crc_eng_pkg::*;

  // Write decode
  logic hit_ctrl, hit_feed, do_clear;
  assign hit_ctrl = bus_wr_en && (bus_addr == ADDR_W'(REG_CTRL));
  assign hit_feed = bus_wr_en && (bus_addr == ADDR_W'(REG_FEED));
  assign do_clear = hit_ctrl && bus_wdata[CLR_BIT];

  // Data bits no register stores
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[BUS_W-1:CLR_BIT+1], bus_wdata[CLR_BIT-1:BYTE_W]};

  // Running checksum
  logic [CRC_W-1:0] crc_q, crc_nxt;

  crc_byte_update #(
    .CRC_W  (CRC_W),
    .BYTE_W (BYTE_W),
    .POLY_R (POLY_R)
  ) u_update (
    .crc_in  (crc_q),
    .byte_in (bus_wdata[BYTE_W-1:0]),
    .crc_out (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || do_clear) begin
      crc_q <= SEED;
    end else if (hit_feed) begin
      crc_q <= crc_nxt;
    end
  end

  // Byte count
  logic [CNT_W-1:0] cnt_q;

  crc_sat_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk (clk),
    .rst (rst),
    .clr (do_clear),
    .inc (hit_feed),
    .cnt (cnt_q)
  );

  // Readback
  crc_readback #(
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .CRC_W  (CRC_W),
    .CNT_W  (CNT_W)
  ) u_read (
    .addr  (bus_addr),
    .cnt   (cnt_q),
    .crc   (crc_q),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/crc_byte_engine_chk.sv
// Property checker attached to the engine.
module crc_byte_engine_chk #(
  parameter int unsigned      BUS_W   = 16,
  parameter int unsigned      ADDR_W  = 3,
  parameter int unsigned      CRC_W   = 16,
  parameter int unsigned      CNT_W   = 12,
  parameter logic [CRC_W-1:0] SEED    = 16'hFFFF,
  parameter int unsigned      CLR_BIT = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [CRC_W-1:0]  crc_q,
  input logic [CNT_W-1:0]  cnt_q
);

  import crc_eng_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wr_ctrl, wr_feed, wr_other;
  assign wr_ctrl  = bus_wr_en && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_feed  = bus_wr_en && (bus_addr == ADDR_W'(REG_FEED));
  assign wr_other = bus_wr_en && !wr_ctrl && !wr_feed;

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[CLR_BIT]) |=> (crc_q == SEED && cnt_q == '0));

  assert_ctrl_noclr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[CLR_BIT]) |=> ($stable(crc_q) && $stable(cnt_q)));

  assert_ctrl_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(REG_CTRL)) |-> (bus_rdata[BUS_W-1:CNT_W] == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_feed && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_feed && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  assert_result_complement_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(REG_FCS)) |-> (bus_rdata[CRC_W-1:0] == ~crc_q));

  assert_other_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_other |=> ($stable(crc_q) && $stable(cnt_q)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_en |=> ($stable(crc_q) && $stable(cnt_q)));

endmodule

bind crc_byte_engine crc_byte_engine_chk #(
  .BUS_W   (BUS_W),
  .ADDR_W  (ADDR_W),
  .CRC_W   (CRC_W),
  .CNT_W   (CNT_W),
  .SEED    (SEED),
  .CLR_BIT (CLR_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .crc_q     (crc_q),
  .cnt_q     (cnt_q)
);

// File: tb/test_crc_byte_engine.sv
module test_crc_byte_engine;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_addr;
  logic        bus_wr_en;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  crc_byte_engine i_crc_byte_engine (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] model;
  int          model_cnt;

  // Bit-serial reference: feedback bit is register LSB xor incoming data bit
  function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    model = 16'hFFFF;
    model_cnt = 0;
  endtask

  task automatic model_feed(logic [15:0] d);
    model = ref_step(model, d[7:0]);
    if (model_cnt < 4095) model_cnt++;
  endtask

  task automatic do_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a == 3'd1) model_feed(d);
    if (a == 3'd0 && d[15]) model_clear();
  endtask

  task automatic do_read(logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_all(string tag);
    logic [15:0] v;
    do_read(3'd0, v); check({tag, " count"}, v, 16'(model_cnt));
    do_read(3'd3, v); check({tag, " raw"}, v, model);
    do_read(3'd2, v); check({tag, " result"}, v, ~model);
  endtask

  // Back-to-back burst of n pseudo-random bytes
  task automatic burst(int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      bus_addr  = 3'd1;
      bus_wdata = d;
      bus_wr_en = 1'b1;
      model_feed(d);
      @(negedge clk);
    end
    bus_wr_en = 1'b0;
  endtask

  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00CC, 16'h3CF5, 16'h00F1, 16'hFFA7,
    16'h0000, 16'h00FF, 16'h1234, 16'h8080
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h1D2C));
    rst = 1'b1; bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check_all("R1 after reset");

    // Table walk: self-test vector, then further patterns with upper-byte junk (R5)
    for (int i = 0; i < NVEC; i++) begin
      do_write(3'd1, VEC[i]);
      check_all("R5 table step");
      if (i == 3) begin
        do_read(3'd0, v); check("R7 self-test count", v, 16'd4);
        do_read(3'd2, v); check("R7 self-test result", v, 16'h51DF);
      end
    end

    // R4: clear bit reads back 0, upper bits zero
    do_write(3'd0, 16'h8000);
    do_read(3'd0, v); check("R4 ctrl readback", v, 16'h0000);
    check_all("R2 after clear");

    // Self-test again back-to-back (R6, R7)
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      bus_addr = 3'd1; bus_wdata = VEC[i]; bus_wr_en = 1'b1;
      model_feed(VEC[i]);
      @(negedge clk);
    end
    bus_wr_en = 1'b0;
    do_read(3'd2, v); check("R6 back-to-back self-test", v, 16'h51DF);
    do_read(3'd0, v); check("R6 back-to-back count", v, 16'd4);

    // R3: control write without clear bit
    do_write(3'd0, 16'h7FFF);
    check_all("R3 ctrl no clear");

    // R9: writes to read-only and unmapped addresses, unmapped reads
    do_write(3'd2, 16'hFFFF);
    do_write(3'd3, 16'h0000);
    do_write(3'd6, 16'h80AA);
    check_all("R9 ignored writes");
    do_read(3'd5, v); check("R9 unmapped read 5", v, 16'h0000);
    do_read(3'd7, v); check("R9 unmapped read 7", v, 16'h0000);

    // R10: idle cycles
    repeat (5) @(negedge clk);
    check_all("R10 idle");

    // Random back-to-back streams (R6, R7)
    for (int s = 0; s < 6; s++) begin
      do_write(3'd0, 16'h8000);
      burst(1 + int'($urandom_range(0, 40)));
      check_all("R6 random stream");
    end

    // Clear mid-stream (R2)
    burst(7);
    do_write(3'd0, 16'hFFFF);
    check_all("R2 clear mid-stream");

    // Saturation (R8)
    burst(4100);
    do_read(3'd0, v); check("R8 count saturated", v, 16'h0FFF);
    check_all("R8 after saturation");
    burst(3);
    check_all("R8 crc still updates");

    // Reset in the middle of state (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_clear();
    check_all("R1 reset again");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule